// File: doc/BRIEF.md
# Serial Converter Device-Side Interface

This block is the digital control side of a small 8-bit serial sampling converter, written so that it can be synthesized. A host sees three wires. The first is a convert-start strobe. The second is a serial clock. The third is a serial data line that the block can release, modelled here as a data bit plus an output enable.

A falling edge on convert-start wakes the block and runs a conversion for a fixed number of system clock cycles. The block then captures the word on `smp_i` and returns to a low-power state while it holds the result. The host reads that result back MSB first using the serial clock. The analog front end is not part of the block. `smp_i` stands in for the successive-approximation result, and `sel_half_o` tells the environment which source should be placed on it: the main input, or the half-supply source.

Both host inputs pass through two-flop synchronizers and are edge-detected in the system clock domain. The serial clock may idle high or low. A convert-start edge that arrives while a conversion is running aborts it and restarts on the half-supply source. A convert-start edge that arrives while a result is still unread also converts the half-supply source. The main input is chosen again only after a result has been read out in full.

Top module: `sadc_dev_if`

## Requirements
- R1: After reset the block is idle: `awake_o`=0 and `sdo_oe_o`=0. If `cnv_i` is held low through reset and afterwards, no conversion starts.
- R2: A falling edge of `cnv_i` seen while idle starts a conversion on the main input (`sel_half_o`=0). `awake_o` is then high for exactly CONV_CYC system cycles.
- R3: A falling edge of `cnv_i` during a conversion aborts it and sets `sel_half_o`=1. A fresh conversion then runs for a full CONV_CYC cycles from that edge.
- R4: While a conversion runs, `sdo_oe_o`=1 and `sdo_o`=0.
- R5: Serial clock edges during a conversion have no effect. A read that follows still starts at bit 7 of the captured word.
- R6: When a conversion ends, `awake_o` drops and `smp_i` is captured. `sdo_oe_o` stays 1 and `sdo_o` shows bit 7. The held value does not change with time or with later changes of `smp_i`.
- R7: Each falling serial clock edge that follows at least one rising edge since capture moves `sdo_o` to the next lower bit, giving straight binary, MSB first. A falling edge that comes before the first rising edge, as with a clock idling high, is ignored.
- R8: On the eighth rising serial clock edge after capture the block returns to idle with `sdo_oe_o`=0.
- R9: A falling edge of `cnv_i` while a result is held and not fully read starts a new conversion with `sel_half_o`=1. After a complete 8-bit read, the next falling edge selects the main input again (`sel_half_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Convert-start strobe from the host, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| smp_i | input | DATA_W | Sample word captured when a conversion ends |
| sel_half_o | output | 1 | Source select: 0 main input, 1 half-supply source |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data drive enable (0 = high impedance) |
| awake_o | output | 1 | High while a conversion is in progress |

## Verification
The assertions assume that `cnv_i` and `sclk_i` hold each level for at least three system cycles, so that every host transition reaches the synchronizer output as a single clean edge. They also assume that `smp_i` is stable in the cycle a conversion ends. The stimulus holds each convert-start level for six cycles and each serial clock phase for four or eight cycles. It changes `smp_i` only while no conversion is about to end.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } conv_st_e;
endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [2:0] q;

  // reset low: a line already low at power-up never looks like a falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[1:0], d_i};
  end

  assign lvl_o  = q[1];
  assign prev_o = q[2];
endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
  import sadc_pkg::*;
#(
  parameter int CONV_CYC = 1875
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cnv_fall_i,
  input  logic     read_done_i,
  output conv_st_e state_o,
  output logic     sel_half_o,
  output logic     load_o
);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);

  conv_st_e       st_q;
  logic           sel_q;
  logic [CW-1:0]  cnt_q;

  // an abort in the final cycle wins over completion
  assign load_o = (st_q == ST_CONV) && !cnv_fall_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cnv_fall_i) begin
          st_q  <= ST_CONV;
          sel_q <= 1'b0;
          cnt_q <= '0;
        end
        ST_CONV: begin
          if (cnv_fall_i) begin
            sel_q <= 1'b1;
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            st_q <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnv_fall_i) begin
            st_q  <= ST_CONV;
            sel_q <= 1'b1;
            cnt_q <= '0;
          end else if (read_done_i) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = st_q;
  assign sel_half_o = sel_q;
endmodule

// File: rtl/sadc_out_shift.sv
module sadc_out_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              msb_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sh_o
);
  localparam int NW = $clog2(DATA_W);
  localparam logic [NW-1:0] LAST_BIT = NW'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [NW-1:0]     rcnt_q;
  logic              seen_q;

  assign done_o = en_i && rise_i && (rcnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rcnt_q <= '0;
      seen_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      rcnt_q <= '0;
      seen_q <= 1'b0;
    end else if (en_i) begin
      if (rise_i) begin
        rcnt_q <= rcnt_q + 1'b1;
        seen_q <= 1'b1;
      end
      // a leading fall (clock idling high) carries no bit
      if (fall_i && seen_q) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign msb_o = sh_q[DATA_W-1];
  assign sh_o  = sh_q;
endmodule

// File: rtl/sadc_dev_if.sv
module sadc_dev_if
  import sadc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CONV_CYC = 1875
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnv_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic              sel_half_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              awake_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw, lvl, prev;
  assign raw = {sclk_i, cnv_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    sadc_edge_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw[g]),
      .lvl_o  (lvl[g]),
      .prev_o (prev[g])
    );
  end

  logic cnv_fall, sclk_rise, sclk_fall;
  assign cnv_fall  = prev[0] & ~lvl[0];
  assign sclk_rise = lvl[1] & ~prev[1];
  assign sclk_fall = prev[1] & ~lvl[1];

  conv_st_e          state;
  logic              load, read_done, msb;
  logic [DATA_W-1:0] sh_q;

  sadc_conv_ctrl #(.CONV_CYC(CONV_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnv_fall_i  (cnv_fall),
    .read_done_i (read_done),
    .state_o     (state),
    .sel_half_o  (sel_half_o),
    .load_o      (load)
  );

  sadc_out_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (smp_i),
    .en_i   (state == ST_HOLD),
    .rise_i (sclk_rise),
    .fall_i (sclk_fall),
    .msb_o  (msb),
    .done_o (read_done),
    .sh_o   (sh_q)
  );

  assign awake_o  = (state == ST_CONV);
  assign sdo_oe_o = (state == ST_CONV) || (state == ST_HOLD);
  assign sdo_o    = (state == ST_HOLD) && msb;
endmodule

// File: rtl/sadc_dev_if_chk.sv
module sadc_dev_if_chk #(
  parameter int DATA_W   = 8,
  parameter int CONV_CYC = 1875
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnv_fall,
  input logic              awake_o,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              sel_half_o,
  input logic [DATA_W-1:0] sh_q
);
  localparam int KW = $clog2(CONV_CYC + 1) + 1;
  logic [KW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!awake_o || cnv_fall) run_q <= '0;
    else                           run_q <= run_q + 1'b1;
  end

  assert_start_on_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awake_o) |-> $past(cnv_fall));

  assert_conv_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |-> (run_q < KW'(CONV_CYC)));

  assert_abort_half_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_o && cnv_fall) |=> (awake_o && sel_half_o));

  assert_low_in_conv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |-> (sdo_oe_o && !sdo_o));

  assert_sclk_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o |=> (!awake_o || $stable(sh_q)));

  assert_release_from_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> $past(!awake_o));
endmodule

bind sadc_dev_if sadc_dev_if_chk #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnv_fall   (cnv_fall),
  .awake_o    (awake_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .sel_half_o (sel_half_o),
  .sh_q       (sh_q)
);

// File: tb/sadc_dev_if_tb.sv
module sadc_dev_if_tb;
  localparam int CONV = 60;
  localparam int HP   = 8;
  localparam int NV   = 6;
  // {sample, clock idles high}
  localparam logic [8:0] VEC [NV] = '{
    {8'hA5, 1'b0}, {8'h00, 1'b1}, {8'hFF, 1'b0},
    {8'h3C, 1'b1}, {8'h81, 1'b0}, {8'h5A, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, sclk = 1'b0;
  logic [7:0] smp = '0;
  logic sel_half, sdo, sdo_oe, awake;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sadc_dev_if #(.DATA_W(8), .CONV_CYC(CONV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sclk_i(sclk), .smp_i(smp),
    .sel_half_o(sel_half), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .awake_o(awake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cnv_fall();
    cnv = 1'b1; tick(6); cnv = 1'b0;
  endtask

  task automatic measure_conv(output int n, output bit low_ok);
    int w = 0;
    n = 0; low_ok = 1'b0;
    while (!awake && w < 20) begin tick(1); w++; end
    low_ok = sdo_oe && !sdo;
    while (awake && n < 4 * CONV) begin
      if (!(sdo_oe && !sdo)) low_ok = 1'b0;
      tick(1); n++;
    end
  endtask

  task automatic read_byte(input bit ih, output logic [7:0] b, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (ih) begin sclk = 1'b0; tick(HP); end
      b[7-i] = sdo;
      if (!sdo_oe) oe_ok = 1'b0;
      sclk = 1'b1; tick(HP);
      if (!ih) begin sclk = 1'b0; tick(HP); end
    end
  endtask

  initial begin
    int n;
    bit low_ok, oe_ok;
    logic [7:0] b;

    // R1: reset with convert-start already low
    rst_n = 1'b0; cnv = 1'b0; sclk = 1'b0;
    tick(5); rst_n = 1'b1; tick(40);
    chk("R1 awake after reset", awake, 0);
    chk("R1 oe after reset", sdo_oe, 0);

    // table walk: R2 R4 R6 R7 R8 (odd rows idle high exercise the ignored leading fall, R7)
    for (int v = 0; v < NV; v++) begin
      sclk = VEC[v][0]; smp = VEC[v][8:1]; tick(6);
      cnv_fall();
      measure_conv(n, low_ok);
      chk("R2 conversion length", n, CONV);
      chk("R2 main input selected", sel_half, 0);
      chk("R4 data low during conversion", low_ok, 1);
      tick(2);
      chk("R6 asleep after conversion", awake, 0);
      chk("R6 msb shown", {sdo_oe, sdo}, {1'b1, smp[7]});
      read_byte(VEC[v][0], b, oe_ok);
      chk("R7 byte read", b, smp);
      chk("R7 driven while reading", oe_ok, 1);
      tick(HP);
      chk("R8 released after eighth pulse", sdo_oe, 0);
    end

    // R5: clock pulses during conversion are ignored
    sclk = 1'b0; smp = 8'hC3; tick(6);
    cnv_fall(); tick(6);
    repeat (3) begin sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    chk("R5 still converting", awake, 1);
    tick(CONV);
    chk("R5 conversion done", awake, 0);
    read_byte(1'b0, b, oe_ok);
    chk("R5 byte intact", b, 8'hC3);

    // R6: result held static, later sample changes have no effect
    smp = 8'hE6; cnv_fall(); tick(CONV + 10);
    smp = 8'h11; tick(200);
    chk("R6 held msb", {sdo_oe, sdo}, 2'b11);
    read_byte(1'b0, b, oe_ok);
    chk("R6 held byte", b, 8'hE6);

    // R3: abort mid-conversion
    smp = 8'h9D; cnv_fall(); tick(20);
    chk("R3 first conversion running", {awake, sel_half}, 2'b10);
    cnv_fall(); tick(6);
    chk("R3 abort selects half-supply", {awake, sel_half}, 2'b11);
    tick(40);
    chk("R3 restarted full length", awake, 1);
    tick(30);
    chk("R3 restarted conversion ends", awake, 0);
    read_byte(1'b0, b, oe_ok);
    chk("R3 byte after abort", b, 8'h9D);

    // R9: new strobe with unread result, then re-arm after full read
    smp = 8'h47; cnv_fall(); tick(CONV + 10);
    repeat (3) begin sclk = 1'b1; tick(HP); sclk = 1'b0; tick(HP); end
    chk("R9 partial read still driven", sdo_oe, 1);
    smp = 8'hB8; cnv_fall(); tick(6);
    chk("R9 unread result gives half-supply", {awake, sel_half}, 2'b11);
    tick(CONV + 10);
    read_byte(1'b0, b, oe_ok);
    chk("R9 new sample from msb", b, 8'hB8);
    cnv_fall(); tick(6);
    chk("R9 re-armed on main input", {awake, sel_half}, 2'b10);
    tick(CONV + 10);
    read_byte(1'b0, b, oe_ok);
    chk("R9 final byte", b, 8'hB8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule